// File: doc/BRIEF.md
# Command Packet Decoder and Dispatcher

The block takes 32-bit words one at a time from the pop side of a command FIFO. It reads each header word and expands the packet that follows it into a series of writes. Register writes, framebuffer writes and texture-memory writes each leave on their own strobe. Jump packets are not expanded: the block hands a new read pointer back to the FIFO controller instead.

Header formats handled:
- no-op and jump packets;
- register runs with an incrementing or fixed index;
- register packets whose targets come from a sparse bit mask;
- bulk memory-write packets.

Words that follow the data of a masked packet and only pad it out are popped and dropped. Vertex-setup packets and byte-lane disables are not decoded.

A single registered write stage drives all three strobes, so at most one write is offered at any time. Writes leave in the order their data words arrive. Backpressure from the targets stops the decoder as a whole: while a write waits for its ready, no FIFO word of any kind is taken.

Top module: `cmdpkt_decoder`

## Requirements
- R1: The packet type is header bits [2:0]. Type 0 with sub-code bits [5:3] = 0 is a no-op: it consumes only its header and produces no write, jump or error, whatever its upper bits hold. A word is taken only in a cycle in which `fifo_valid` is high.
- R2: Type 0 with sub-code 3 is a jump. In the cycle after the header is taken, `ptr_load` is high for exactly one cycle and `ptr_value` equals (header >> 4) & 0xFFFFFC. No word is taken in that cycle. The next word taken is treated as a header.
- R3: Type 1 carries a word count in bits [31:16], a starting register index in bits [14:3] and an increment flag in bit 15. Each of the count data words produces one register write. The index advances by one per word (modulo 4096) when the flag is 1 and stays fixed when it is 0. A count of 0 produces no write.
- R4: Type 2 uses header >> 3 (29 bits) as a mask, and its index base is the parameter `BLT_BASE_IDX` (default 0x0C0). Mask bits are scanned from bit 0 upward. Each set bit n takes one data word and writes it to index base + n. The packet ends as soon as no set bits remain, and a zero mask takes no data.
- R5: Type 4 uses bits [28:15] as a mask and bits [14:3] as the index base, and follows the same scan as R4. It then takes and drops the number of words given in bits [31:29]. This also applies when the mask is zero, and the dropped words cause no write or error.
- R6: Type 5 carries a word count in bits [21:3] and a destination in bits [31:30]: 2 selects the framebuffer strobe and 3 selects the texture strobe. The word after the header gives the start address as (word & 0xFFFFFF) >> 2. The address advances by one per data word, modulo 2^22. A count of 0 takes only the address word.
- R7: Types 3, 6 and 7, type 0 sub-codes other than 0 and 3, and type 5 destinations 0 and 1 are all unsupported. Each raises `err_pulse` for one cycle, in the cycle after its header is taken. No further word belongs to that packet: the next word taken is a header.
- R8: While a write strobe is high and its ready is low, the strobe, index or address, and data stay unchanged, and `fifo_pop` stays low.
- R9: At most one of the three write strobes is high in any cycle. Accepted writes appear in the order of their data words in the stream.
- R10: While `rst` is high and in the first cycle after it, all write strobes, `ptr_load` and `err_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_valid | input | 1 | FIFO presents a word |
| fifo_data | input | 32 | Word at the FIFO head |
| fifo_pop | output | 1 | Word at the head is taken this cycle |
| ptr_load | output | 1 | One-cycle request to reload the FIFO read pointer |
| ptr_value | output | 24 | Byte read pointer for a jump |
| err_pulse | output | 1 | One-cycle flag for an unsupported header |
| reg_wr_valid | output | 1 | Register write strobe |
| reg_wr_idx | output | 12 | Register index of the write |
| reg_wr_ready | input | 1 | Register target accepts the write |
| fb_wr_valid | output | 1 | Framebuffer write strobe |
| tex_wr_valid | output | 1 | Texture-memory write strobe |
| mem_wr_addr | output | 22 | Word address of a framebuffer or texture write |
| mem_wr_ready | input | 1 | Memory target accepts the write |
| wr_data | output | 32 | Data of the pending write |

## Verification
The overlap that matters is between the last write of a packet, still held by a low ready, and the fetch of the next header. That header may be a jump, an error or the start of another run. The stream is replayed under three ready patterns (always ready, pseudo-random, and mostly stalled) so that final writes of packets are often held while the next header waits. The bench compares the accepted writes and the jump and error events as two separate ordered lists against lists computed from the header fields. In every stalled cycle it also checks that the held write does not change and that nothing is popped.

// File: rtl/cmdpkt_pkg.sv
`timescale 1ns/1ps
package cmdpkt_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 12;
    localparam int MASK_W = 29;
    localparam int CNT_W  = 19;
    localparam int ADDR_W = 22;
    localparam int PTR_W  = 24;
    localparam int PAD_W  = 3;

    typedef enum logic [2:0] {
        K_NOP, K_JUMP, K_REG_SEQ, K_REG_MASK, K_MEM_FB, K_MEM_TEX, K_BAD
    } pkt_kind_e;

    typedef enum logic [1:0] {D_REG, D_FB, D_TEX} wr_dest_e;

    typedef enum logic [2:0] {ST_HDR, ST_ADDR, ST_DATA, ST_PAD, ST_JUMP} dec_state_e;

    typedef struct packed {
        pkt_kind_e          kind;
        logic               inc;
        logic [CNT_W-1:0]   count;
        logic [IDX_W-1:0]   idx;
        logic [MASK_W-1:0]  mask;
        logic [PAD_W-1:0]   pad;
        logic [PTR_W-1:0]   jump_ptr;
    } hdr_info_t;

    typedef struct packed {
        wr_dest_e           dest;
        logic [IDX_W-1:0]   idx;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  data;
    } wr_req_t;

    // start word address carried by the word after a memory-write header
    function automatic logic [ADDR_W-1:0] mem_start(input logic [WORD_W-1:0] w);
        return w[ADDR_W+1:2];
    endfunction

endpackage

// File: rtl/cmdpkt_hdr_decode.sv
`timescale 1ns/1ps
module cmdpkt_hdr_decode
    import cmdpkt_pkg::*;
#(
    parameter logic [IDX_W-1:0] BLT_BASE = 12'h0C0
) (
    input  logic [WORD_W-1:0] hdr,
    output hdr_info_t         info
);

    always_comb begin
        info      = '0;
        info.kind = K_BAD;
        case (hdr[2:0])
            3'd0: begin
                if (hdr[5:3] == 3'd0) begin
                    info.kind = K_NOP;
                end else if (hdr[5:3] == 3'd3) begin
                    info.kind     = K_JUMP;
                    info.jump_ptr = {hdr[PTR_W+3:6], 2'b00};
                end
            end
            3'd1: begin
                info.kind  = K_REG_SEQ;
                info.count = CNT_W'(hdr[31:16]);
                info.inc   = hdr[15];
                info.idx   = hdr[14:3];
            end
            3'd2: begin
                info.kind = K_REG_MASK;
                info.idx  = BLT_BASE;
                info.mask = hdr[31:3];
            end
            3'd4: begin
                info.kind = K_REG_MASK;
                info.idx  = hdr[14:3];
                info.mask = {{(MASK_W-14){1'b0}}, hdr[28:15]};
                info.pad  = hdr[31:29];
            end
            3'd5: begin
                info.count = hdr[21:3];
                if (hdr[31:30] == 2'b10)      info.kind = K_MEM_FB;
                else if (hdr[31:30] == 2'b11) info.kind = K_MEM_TEX;
            end
            default: info.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/cmdpkt_lsb_find.sv
`timescale 1ns/1ps
module cmdpkt_lsb_find #(
    parameter  int W  = 29,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] pos
);

    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) pos = IW'(i);
        end
    end

endmodule

// File: rtl/cmdpkt_decoder.sv
`timescale 1ns/1ps
module cmdpkt_decoder
    import cmdpkt_pkg::*;
#(
    parameter logic [IDX_W-1:0] BLT_BASE_IDX = 12'h0C0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_valid,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_value,
    output logic              err_pulse,
    output logic              reg_wr_valid,
    output logic [IDX_W-1:0]  reg_wr_idx,
    input  logic              reg_wr_ready,
    output logic              fb_wr_valid,
    output logic              tex_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    input  logic              mem_wr_ready,
    output logic [WORD_W-1:0] wr_data
);

    localparam int POS_W = $clog2(MASK_W);

    dec_state_e          state_q;
    pkt_kind_e           kind_q;
    logic                inc_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [IDX_W-1:0]    idx_q;
    logic [MASK_W-1:0]   mask_q;
    logic [PAD_W-1:0]    pad_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [PTR_W-1:0]    ptr_q;
    logic                err_q;
    wr_req_t             out_q;
    logic                out_vld_q;

    hdr_info_t           hinfo;
    logic [POS_W-1:0]    bit_pos;
    logic [MASK_W-1:0]   mask_clr;
    logic                out_accept;
    logic                out_free;

    cmdpkt_hdr_decode #(.BLT_BASE(BLT_BASE_IDX)) u_hdr (
        .hdr  (fifo_data),
        .info (hinfo)
    );

    cmdpkt_lsb_find #(.W(MASK_W)) u_lsb (
        .vec (mask_q),
        .pos (bit_pos)
    );

    assign mask_clr   = mask_q & ~(MASK_W'(1) << bit_pos);
    assign out_accept = out_vld_q && ((out_q.dest == D_REG) ? reg_wr_ready : mem_wr_ready);
    assign out_free   = !out_vld_q || out_accept;

    always_comb begin
        fifo_pop = 1'b0;
        if (state_q != ST_JUMP) fifo_pop = fifo_valid && out_free;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_HDR;
            kind_q    <= K_NOP;
            inc_q     <= 1'b0;
            cnt_q     <= '0;
            idx_q     <= '0;
            mask_q    <= '0;
            pad_q     <= '0;
            addr_q    <= '0;
            ptr_q     <= '0;
            err_q     <= 1'b0;
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (out_accept) out_vld_q <= 1'b0;
            case (state_q)
                ST_HDR: if (fifo_pop) begin
                    case (hinfo.kind)
                        K_NOP: ;
                        K_JUMP: begin
                            ptr_q   <= hinfo.jump_ptr;
                            state_q <= ST_JUMP;
                        end
                        K_REG_SEQ: begin
                            kind_q  <= K_REG_SEQ;
                            idx_q   <= hinfo.idx;
                            inc_q   <= hinfo.inc;
                            cnt_q   <= hinfo.count;
                            state_q <= (hinfo.count == '0) ? ST_HDR : ST_DATA;
                        end
                        K_REG_MASK: begin
                            kind_q <= K_REG_MASK;
                            idx_q  <= hinfo.idx;
                            mask_q <= hinfo.mask;
                            pad_q  <= hinfo.pad;
                            if (hinfo.mask != '0)     state_q <= ST_DATA;
                            else if (hinfo.pad != '0) state_q <= ST_PAD;
                            else                      state_q <= ST_HDR;
                        end
                        K_MEM_FB, K_MEM_TEX: begin
                            kind_q  <= hinfo.kind;
                            cnt_q   <= hinfo.count;
                            state_q <= ST_ADDR;
                        end
                        default: err_q <= 1'b1;
                    endcase
                end
                ST_ADDR: if (fifo_pop) begin
                    addr_q  <= mem_start(fifo_data);
                    state_q <= (cnt_q == '0) ? ST_HDR : ST_DATA;
                end
                ST_DATA: if (fifo_pop) begin
                    out_vld_q  <= 1'b1;
                    out_q.data <= fifo_data;
                    case (kind_q)
                        K_REG_SEQ: begin
                            out_q.dest <= D_REG;
                            out_q.idx  <= idx_q;
                            if (inc_q) idx_q <= idx_q + 1'b1;
                            cnt_q <= cnt_q - 1'b1;
                            if (cnt_q == CNT_W'(1)) state_q <= ST_HDR;
                        end
                        K_REG_MASK: begin
                            out_q.dest <= D_REG;
                            out_q.idx  <= idx_q + IDX_W'(bit_pos);
                            mask_q     <= mask_clr;
                            if (mask_clr == '0) state_q <= (pad_q != '0) ? ST_PAD : ST_HDR;
                        end
                        default: begin
                            out_q.dest <= (kind_q == K_MEM_TEX) ? D_TEX : D_FB;
                            out_q.addr <= addr_q;
                            addr_q     <= addr_q + 1'b1;
                            cnt_q      <= cnt_q - 1'b1;
                            if (cnt_q == CNT_W'(1)) state_q <= ST_HDR;
                        end
                    endcase
                end
                ST_PAD: if (fifo_pop) begin
                    pad_q <= pad_q - 1'b1;
                    if (pad_q == PAD_W'(1)) state_q <= ST_HDR;
                end
                default: state_q <= ST_HDR;
            endcase
        end
    end

    assign reg_wr_valid = out_vld_q && (out_q.dest == D_REG);
    assign fb_wr_valid  = out_vld_q && (out_q.dest == D_FB);
    assign tex_wr_valid = out_vld_q && (out_q.dest == D_TEX);
    assign reg_wr_idx   = out_q.idx;
    assign mem_wr_addr  = out_q.addr;
    assign wr_data      = out_q.data;
    assign ptr_load     = (state_q == ST_JUMP);
    assign ptr_value    = ptr_q;
    assign err_pulse    = err_q;

endmodule

// File: rtl/cmdpkt_decoder_chk.sv
`timescale 1ns/1ps
module cmdpkt_decoder_chk
    import cmdpkt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fifo_valid,
    input logic              fifo_pop,
    input logic              ptr_load,
    input logic              err_pulse,
    input logic              reg_wr_valid,
    input logic [IDX_W-1:0]  reg_wr_idx,
    input logic              reg_wr_ready,
    input logic              fb_wr_valid,
    input logic              tex_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              mem_wr_ready,
    input logic [WORD_W-1:0] wr_data
);

    logic mem_stall;
    logic reg_stall;
    assign mem_stall = (fb_wr_valid || tex_wr_valid) && !mem_wr_ready;
    assign reg_stall = reg_wr_valid && !reg_wr_ready;

    assert_pop_valid_R1: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> fifo_valid);

    assert_ptr_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        ptr_load |=> !ptr_load);

    assert_ptr_nopop_R2: assert property (@(posedge clk) disable iff (rst)
        ptr_load |-> !fifo_pop);

    assert_err_after_pop_R7: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(fifo_pop));

    assert_reg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        reg_stall |=> (reg_wr_valid && $stable(reg_wr_idx) && $stable(wr_data)));

    assert_mem_hold_R8: assert property (@(posedge clk) disable iff (rst)
        mem_stall |=> ($stable(fb_wr_valid) && $stable(tex_wr_valid) &&
                       $stable(mem_wr_addr) && $stable(wr_data)));

    assert_no_pop_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_stall || mem_stall) |-> !fifo_pop);

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_wr_valid, fb_wr_valid, tex_wr_valid}));

endmodule

bind cmdpkt_decoder cmdpkt_decoder_chk u_chk (.*);

// File: tb/cmdpkt_decoder_tb.sv
`timescale 1ns/1ps
module cmdpkt_decoder_tb;
    import cmdpkt_pkg::*;

    localparam logic [11:0] BASE = 12'h0C0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_valid;
    logic [31:0] fifo_data;
    logic        fifo_pop;
    logic        ptr_load;
    logic [23:0] ptr_value;
    logic        err_pulse;
    logic        reg_wr_valid;
    logic [11:0] reg_wr_idx;
    logic        reg_wr_ready = 1'b1;
    logic        fb_wr_valid;
    logic        tex_wr_valid;
    logic [21:0] mem_wr_addr;
    logic        mem_wr_ready = 1'b1;
    logic [31:0] wr_data;

    cmdpkt_decoder #(.BLT_BASE_IDX(BASE)) u_dut (.*);

    always #2.5 clk = ~clk;

    // stream source standing in for the FIFO
    logic [31:0] stream [0:2047];
    int n_words = 0;
    int rd;
    assign fifo_valid = (rd < n_words);
    assign fifo_data  = stream[rd];

    always @(posedge clk) begin
        if (rst)           rd <= 0;
        else if (ptr_load) rd <= int'(ptr_value >> 2);
        else if (fifo_pop) rd <= rd + 1;
    end

    // expected and observed event lists
    int    exp_k [0:4095]; int exp_a [0:4095]; logic [31:0] exp_d [0:4095]; string exp_t [0:4095];
    int    obs_k [0:4095]; int obs_a [0:4095]; logic [31:0] obs_d [0:4095];
    int    cexp_k [0:255]; int cexp_v [0:255]; string cexp_t [0:255];
    int    cobs_k [0:255]; int cobs_v [0:255];
    int n_exp = 0, n_obs = 0, n_cexp = 0, n_cobs = 0;

    int n_chk = 0, n_fail = 0;
    int mode = 0;
    int seq = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic monitor_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        stream[n_words] = w;
        n_words++;
    endtask

    task automatic expw(input int k, input int a, input logic [31:0] d, input string t);
        exp_k[n_exp] = k; exp_a[n_exp] = a; exp_d[n_exp] = d; exp_t[n_exp] = t;
        n_exp++;
    endtask

    task automatic expc(input int k, input int v, input string t);
        cexp_k[n_cexp] = k; cexp_v[n_cexp] = v; cexp_t[n_cexp] = t;
        n_cexp++;
    endtask

    function automatic logic [31:0] nd();
        seq++;
        return 32'h5A00_0000 ^ (seq * 32'h0001_9E37);
    endfunction

    task automatic pkt_seq(input logic [15:0] cnt, input logic [11:0] idx, input logic inc);
        logic [31:0] d;
        push({cnt, inc, idx, 3'd1});
        for (int k = 0; k < int'(cnt); k++) begin
            d = nd();
            push(d);
            expw(1, (int'(idx) + (inc ? k : 0)) & 12'hFFF, d, "R3");
        end
    endtask

    task automatic pkt_mask(input bit t4, input logic [28:0] mask, input logic [11:0] idx,
                            input logic [2:0] pad);
        logic [31:0] d;
        int base;
        int w;
        base = t4 ? int'(idx) : int'(BASE);
        w    = t4 ? 14 : 29;
        if (t4) push({pad, mask[13:0], idx, 3'd4});
        else    push({mask, 3'd2});
        for (int b = 0; b < w; b++) begin
            if (mask[b]) begin
                d = nd();
                push(d);
                expw(1, (base + b) & 12'hFFF, d, t4 ? "R5" : "R4");
            end
        end
        if (t4) for (int p = 0; p < int'(pad); p++) push(32'hBAD0_0007);
    endtask

    task automatic pkt_mem(input bit tex, input logic [18:0] cnt, input logic [31:0] aw);
        logic [31:0] d;
        int a0;
        push({tex ? 2'b11 : 2'b10, 8'h00, cnt, 3'd5});
        push(aw);
        a0 = int'(aw[23:2]);
        for (int k = 0; k < int'(cnt); k++) begin
            d = nd();
            push(d);
            expw(tex ? 3 : 2, (a0 + k) & 22'h3FFFFF, d, "R6");
        end
    endtask

    task automatic pkt_bad(input logic [31:0] w);
        push(w);
        expc(5, 0, "R7");
    endtask

    task automatic pkt_jump(input int skip);
        int tgt;
        tgt = n_words + 1 + skip;
        push((tgt << 6) | (3 << 3));
        expc(4, tgt * 4, "R2");
        for (int s = 0; s < skip; s++) push(32'h0000_0007);
    endtask

    task automatic build();
        logic [28:0] m2 [0:5];
        logic [13:0] m4 [0:4];
        m2[0] = 29'h0; m2[1] = 29'h1; m2[2] = 29'h15; m2[3] = 29'h1000_0000;
        m2[4] = 29'h1FFF_FFFF; m2[5] = 29'h0AAA_AAAA;
        m4[0] = 14'h0; m4[1] = 14'h1; m4[2] = 14'h2001; m4[3] = 14'h3FFF; m4[4] = 14'h1234;
        push(32'h0000_0000);                       // R1 plain no-op
        push(32'hFFFF_FFC0);                       // R1 no-op with upper bits set
        for (int c = 0; c < 5; c++)
            for (int i = 0; i < 2; i++) begin
                pkt_seq(16'(c), 12'h005, 1'(i));
                pkt_seq(16'(c), 12'hFFE, 1'(i));
            end
        for (int j = 0; j < 6; j++) pkt_mask(1'b0, m2[j], 12'h0, 3'd0);
        for (int p = 0; p < 8; p++)
            for (int j = 0; j < 5; j++) begin
                pkt_mask(1'b1, {15'h0, m4[j]}, 12'h010, 3'(p));
                pkt_mask(1'b1, {15'h0, m4[j]}, 12'hFFC, 3'(p));
            end
        for (int t = 0; t < 2; t++)
            for (int c = 0; c < 4; c++) begin
                pkt_mem(1'(t), 19'(c), 32'hAB00_0010);
                pkt_mem(1'(t), 19'(c), 32'hFFFF_FFFC);
            end
        pkt_bad(32'h0000_0003); pkt_seq(16'd2, 12'h020, 1'b1);
        pkt_bad(32'h0000_0006); pkt_bad(32'h0000_0007);
        for (int c = 1; c < 8; c++)
            if (c != 3) begin
                pkt_bad({26'h0, 3'(c), 3'd0});
                pkt_mem(1'b0, 19'd1, 32'h0000_0100);
            end
        pkt_bad({2'b00, 8'h00, 19'd2, 3'd5});
        pkt_bad({2'b01, 8'h00, 19'd2, 3'd5});
        pkt_seq(16'd3, 12'h030, 1'b0);
        pkt_jump(3);
        pkt_seq(16'd2, 12'h040, 1'b1);
        pkt_jump(0);
        pkt_mem(1'b1, 19'd2, 32'h0000_0040);
        pkt_jump(2);
        pkt_mask(1'b1, 29'h5, 12'h050, 3'd1);
    endtask

    // ready drive and output monitor, half a cycle away from the active edge
    initial begin
        logic        p_rs, p_ms;
        logic [11:0] p_idx;
        logic [21:0] p_addr;
        logic [31:0] p_data;
        logic        p_fb;
        p_rs = 0; p_ms = 0; p_idx = 0; p_addr = 0; p_data = 0; p_fb = 0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: begin reg_wr_ready = 1'b1; mem_wr_ready = 1'b1; end
                1: begin reg_wr_ready = lfsr[0]; mem_wr_ready = lfsr[3]; end
                default: begin reg_wr_ready = (lfsr[1:0] == 2'b00); mem_wr_ready = (lfsr[5:4] == 2'b00); end
            endcase
            #1;
            if (monitor_on && !rst) begin
                if (p_rs) chk(reg_wr_valid && reg_wr_idx == p_idx && wr_data == p_data,
                              "R8", "held register write", {reg_wr_idx, wr_data}, {p_idx, p_data});
                if (p_ms) chk((p_fb ? fb_wr_valid : tex_wr_valid) && mem_wr_addr == p_addr && wr_data == p_data,
                              "R8", "held memory write", {mem_wr_addr, wr_data}, {p_addr, p_data});
                if ((reg_wr_valid && !reg_wr_ready) || ((fb_wr_valid || tex_wr_valid) && !mem_wr_ready))
                    chk(!fifo_pop, "R8", "pop during stall", 64'(fifo_pop), 64'd0);
                if (reg_wr_valid || fb_wr_valid || tex_wr_valid)
                    chk($countones({reg_wr_valid, fb_wr_valid, tex_wr_valid}) == 1, "R9", "strobe count",
                        64'($countones({reg_wr_valid, fb_wr_valid, tex_wr_valid})), 64'd1);
                if (ptr_load) chk(!fifo_pop, "R2", "pop during pointer load", 64'(fifo_pop), 64'd0);
                if (reg_wr_valid && reg_wr_ready) begin
                    obs_k[n_obs] = 1; obs_a[n_obs] = int'(reg_wr_idx); obs_d[n_obs] = wr_data; n_obs++;
                end
                if ((fb_wr_valid || tex_wr_valid) && mem_wr_ready) begin
                    obs_k[n_obs] = fb_wr_valid ? 2 : 3; obs_a[n_obs] = int'(mem_wr_addr);
                    obs_d[n_obs] = wr_data; n_obs++;
                end
                if (ptr_load)  begin cobs_k[n_cobs] = 4; cobs_v[n_cobs] = int'(ptr_value); n_cobs++; end
                if (err_pulse) begin cobs_k[n_cobs] = 5; cobs_v[n_cobs] = 0; n_cobs++; end
            end
            p_rs = reg_wr_valid && !reg_wr_ready;
            p_ms = (fb_wr_valid || tex_wr_valid) && !mem_wr_ready;
            p_fb = fb_wr_valid;
            p_idx = reg_wr_idx; p_addr = mem_wr_addr; p_data = wr_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", n_obs, n_exp);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int idle;
        build();
        for (int m = 0; m < 3; m++) begin
            mode = m;
            monitor_on = 1'b0;
            rst = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk); #1;
            chk(!reg_wr_valid && !fb_wr_valid && !tex_wr_valid && !ptr_load && !err_pulse,
                "R10", "outputs in reset",
                {reg_wr_valid, fb_wr_valid, tex_wr_valid, ptr_load, err_pulse}, 64'd0);
            n_obs = 0; n_cobs = 0;
            monitor_on = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            @(negedge clk); #1.5;
            chk(!reg_wr_valid && !fb_wr_valid && !tex_wr_valid && !ptr_load && !err_pulse,
                "R10", "outputs after reset",
                {reg_wr_valid, fb_wr_valid, tex_wr_valid, ptr_load, err_pulse}, 64'd0);
            idle = 0;
            while (idle < 20) begin
                @(negedge clk); #1.5;
                if (rd >= n_words && !reg_wr_valid && !fb_wr_valid && !tex_wr_valid && !ptr_load) idle++;
                else idle = 0;
            end
            chk(n_obs == n_exp, "R9", "write count", 64'(n_obs), 64'(n_exp));
            for (int i = 0; i < n_exp && i < n_obs; i++)
                chk(obs_k[i] == exp_k[i] && obs_a[i] == exp_a[i] && obs_d[i] == exp_d[i],
                    exp_t[i], "write kind/target/data",
                    {8'(obs_k[i]), 24'(obs_a[i]), obs_d[i]}, {8'(exp_k[i]), 24'(exp_a[i]), exp_d[i]});
            chk(n_cobs == n_cexp, "R7", "jump/error event count", 64'(n_cobs), 64'(n_cexp));
            for (int i = 0; i < n_cexp && i < n_cobs; i++)
                chk(cobs_k[i] == cexp_k[i] && cobs_v[i] == cexp_v[i], cexp_t[i], "jump/error event",
                    {32'(cobs_k[i]), 32'(cobs_v[i])}, {32'(cexp_k[i]), 32'(cexp_v[i])});
            // R1: no-op headers leave no trace beyond the lists compared above
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule